// File: doc/BRIEF.md
# Flash command window register file

This block is the device-side register window of a memory-mapped flash command interface. A host on a simple single-cycle read/write bus fills a set of command registers, then starts the command by writing one legal value to a dedicated execute register. The registers are a command code, a command data word, a two-half command address and a two-half data count. The window also returns fixed identification words. These are a four-character query signature, a manufacturer and device code, and the location and word size of the program buffer.

Program and erase operations are modelled by an operation timer. While the timer runs, the ready bit is low and register writes are ignored. A running operation can be suspended and later resumed, and the remaining time is kept across the suspend. A small per-block lock table can refuse program and erase commands. A low-supply input pin can abort an operation at start. Result inputs from the (absent) array are captured into error bits when an operation finishes. The error bits in the status word clear when that word is read.

Top module: `flash_cmd_window`

## Requirements
- R1: Reads at 0x00, 0x02, 0x04, 0x06 return 0x0050, 0x0046, 0x004F, 0x0057. Reads at 0x20, 0x22, 0x40, 0x42 return the parameters MFR_ID, DEV_ID, PBUF_LOC and PBUF_WORDS.
- R2: The registers at 0x80 (code), 0x84 (data), 0x88/0x8A (address low/high) and 0x90/0x92 (count low/high) read back the last accepted write and reset to 0. Unmapped offsets read 0.
- R3: A command starts only when 0x0001 is written to 0xC0. A write of any other value there has no effect, and ready stays 1.
- R4: Codes 0x41 and 0xE9 are program operations lasting PROG_CYCLES cycles, and code 0x20 is an erase lasting ERASE_CYCLES cycles. Status bit 7 and the ready output are 0 for exactly that time. Any other code has no effect.
- R5: While an operation runs (not suspended), register writes are ignored, except a suspend write.
- R6: Writing 0x0001 to 0xC8 during a run suspends it. Status bit 2 is set for a program or bit 6 for an erase, ready returns to 1 and the timer freezes.
- R7: Executing code 0xD0 while suspended clears the suspend bit and finishes the operation after the cycles that remained. Any other code executed while suspended is ignored.
- R8: Code 0x61 locks and 0x62 unlocks the block indexed by the low bits of the address-high register. A program or erase to a locked block sets status bit 1 and does not start.
- R9: If the vpp_low pin is 1 when an unlocked program or erase is executed, status bit 3 is set and the operation does not start.
- R10: When a program finishes, bit 4 takes prog_fail, bits 9:8 take region_code (00 success, 01 reprogram of object-mode region, 10 object-mode program into control-mode region, 11 invalid-half word program) and bit 12 takes ao_fail. When an erase finishes, bit 5 takes erase_fail and bit 12 takes ao_fail.
- R11: Status at 0xCC has bit 15 always 1. Reading it returns the current word and then clears the bits in mask 0x133A. Bits 2, 6, 7 and 15 are not cleared by the read.
- R12: Writing 0x0001 to 0xC4 while not running gives a one-cycle buf_clear pulse on the following cycle. Other values give no pulse.
- R13: Read data and rd_valid appear in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| vpp_low | input | 1 | Low programming supply indication |
| prog_fail | input | 1 | Program result from the array |
| erase_fail | input | 1 | Erase/blank-check result from the array |
| region_code | input | 2 | Region program result code |
| ao_fail | input | 1 | AO-related failure result |
| ready | output | 1 | 1 when no operation is running |
| buf_clear | output | 1 | Program buffer clear pulse |

## Verification
The hardest state to reach is a resumed operation that must still end on the exact cycle set by the time left at suspend. The suspend write must land a known number of cycles into an erase. The design then idles while suspended, and the resume code and execute are issued through the normal window. The bench then samples ready one cycle before and exactly at the expected finish. This single measurement also checks that the timer stayed frozen across the suspend. Read-clear is checked by reading the status twice after each error event, so that a cleared bit and a surviving read-only bit show in the same pair of reads.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  localparam logic [7:0] OFS_SIG0     = 8'h00;
  localparam logic [7:0] OFS_SIG1     = 8'h02;
  localparam logic [7:0] OFS_SIG2     = 8'h04;
  localparam logic [7:0] OFS_SIG3     = 8'h06;
  localparam logic [7:0] OFS_MFR      = 8'h20;
  localparam logic [7:0] OFS_DEV      = 8'h22;
  localparam logic [7:0] OFS_PBLOC    = 8'h40;
  localparam logic [7:0] OFS_PBSZ     = 8'h42;
  localparam logic [7:0] OFS_CODE     = 8'h80;
  localparam logic [7:0] OFS_DATA     = 8'h84;
  localparam logic [7:0] OFS_ADR_LO   = 8'h88;
  localparam logic [7:0] OFS_ADR_HI   = 8'h8A;
  localparam logic [7:0] OFS_CNT_LO   = 8'h90;
  localparam logic [7:0] OFS_CNT_HI   = 8'h92;
  localparam logic [7:0] OFS_GO       = 8'hC0;
  localparam logic [7:0] OFS_BUFCLR   = 8'hC4;
  localparam logic [7:0] OFS_HOLD     = 8'hC8;
  localparam logic [7:0] OFS_STAT     = 8'hCC;

  localparam logic [15:0] STROBE_VAL  = 16'h0001;

  localparam logic [15:0] OP_WORD_PGM = 16'h0041;
  localparam logic [15:0] OP_BUF_PGM  = 16'h00E9;
  localparam logic [15:0] OP_ERASE    = 16'h0020;
  localparam logic [15:0] OP_LOCK     = 16'h0061;
  localparam logic [15:0] OP_UNLOCK   = 16'h0062;
  localparam logic [15:0] OP_RESUME   = 16'h00D0;

  localparam logic [15:0] ERR_MASK    = 16'h133A;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_SUSP} seq_st_t;

  function automatic logic is_prog_op(input logic [15:0] code);
    return (code == OP_WORD_PGM) || (code == OP_BUF_PGM);
  endfunction

  function automatic logic is_timed_op(input logic [15:0] code);
    return is_prog_op(code) || (code == OP_ERASE);
  endfunction

  // Error bits raised by one cycle's events.
  function automatic logic [15:0] err_events(
    input logic lock_abort, input logic vpp_abort,
    input logic done_prog, input logic done_erase,
    input logic prog_fail, input logic erase_fail,
    input logic [1:0] region, input logic ao_fail);
    logic [15:0] e;
    e = '0;
    e[1]   = lock_abort;
    e[3]   = vpp_abort;
    e[4]   = done_prog & prog_fail;
    e[5]   = done_erase & erase_fail;
    e[9:8] = done_prog ? region : 2'b00;
    e[12]  = (done_prog | done_erase) & ao_fail;
    return e & ERR_MASK;
  endfunction

  function automatic logic [15:0] status_word(
    input logic [15:0] err, input logic rdy,
    input logic pgm_susp, input logic ers_susp);
    logic [15:0] s;
    s     = err & ERR_MASK;
    s[15] = 1'b1;
    s[7]  = rdy;
    s[6]  = ers_susp;
    s[2]  = pgm_susp;
    return s;
  endfunction

endpackage

// File: rtl/fcw_regs.sv
module fcw_regs
  import fcw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              block_wr,
  output logic [DW-1:0]     code_q,
  output logic [DW-1:0]     data_q,
  output logic [DW-1:0]     adr_lo_q,
  output logic [DW-1:0]     adr_hi_q,
  output logic [DW-1:0]     cnt_lo_q,
  output logic [DW-1:0]     cnt_hi_q,
  output logic              exec_go,
  output logic              susp_go,
  output logic              clr_go
);

  logic wr_ok;
  logic strobe_val;
  assign wr_ok      = wr_en && !block_wr;
  assign strobe_val = (wdata == DW'(STROBE_VAL));

  assign exec_go = wr_ok && (addr == ADDR_W'(OFS_GO))     && strobe_val;
  assign clr_go  = wr_ok && (addr == ADDR_W'(OFS_BUFCLR)) && strobe_val;
  assign susp_go = wr_en && (addr == ADDR_W'(OFS_HOLD))   && strobe_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      data_q   <= '0;
      adr_lo_q <= '0;
      adr_hi_q <= '0;
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else if (wr_ok) begin
      if (addr == ADDR_W'(OFS_CODE))   code_q   <= wdata;
      if (addr == ADDR_W'(OFS_DATA))   data_q   <= wdata;
      if (addr == ADDR_W'(OFS_ADR_LO)) adr_lo_q <= wdata;
      if (addr == ADDR_W'(OFS_ADR_HI)) adr_hi_q <= wdata;
      if (addr == ADDR_W'(OFS_CNT_LO)) cnt_lo_q <= wdata;
      if (addr == ADDR_W'(OFS_CNT_HI)) cnt_hi_q <= wdata;
    end
  end

  p_code_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    block_wr |=> $stable(code_q) && $stable(adr_hi_q) && $stable(data_q));

  p_no_go_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    block_wr |-> !exec_go && !clr_go);

endmodule

// File: rtl/fcw_seq.sv
module fcw_seq
  import fcw_pkg::*;
#(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 40,
  parameter int NUM_BLOCKS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exec_go,
  input  logic        susp_go,
  input  logic [15:0] code,
  input  logic [15:0] blk_sel,
  input  logic        vpp_low,
  output logic        running,
  output logic        pgm_susp,
  output logic        ers_susp,
  output logic        lock_abort,
  output logic        vpp_abort,
  output logic        done_prog,
  output logic        done_erase
);

  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int TW    = $clog2(MAXC + 1);
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

  seq_st_t          st_q;
  logic [TW-1:0]    tmr_q;
  logic             op_prog_q;
  logic [NUM_BLOCKS-1:0] lock_q;
  logic [BLK_W-1:0] blk;
  logic             blk_locked;
  logic             idle_go;
  logic             start_op;
  logic             resume_op;
  logic             tmr_last;

  assign blk        = blk_sel[BLK_W-1:0];
  assign blk_locked = lock_q[blk];
  assign idle_go    = exec_go && (st_q == SQ_IDLE);

  assign lock_abort = idle_go && is_timed_op(code) && blk_locked;
  assign vpp_abort  = idle_go && is_timed_op(code) && !blk_locked && vpp_low;
  assign start_op   = idle_go && is_timed_op(code) && !blk_locked && !vpp_low;
  assign resume_op  = exec_go && (st_q == SQ_SUSP) && (code == OP_RESUME);

  assign running    = (st_q == SQ_RUN);
  assign tmr_last   = running && (tmr_q == TW'(1));
  assign done_prog  = tmr_last && op_prog_q;
  assign done_erase = tmr_last && !op_prog_q;
  assign pgm_susp   = (st_q == SQ_SUSP) && op_prog_q;
  assign ers_susp   = (st_q == SQ_SUSP) && !op_prog_q;

  genvar g;
  generate
    for (g = 0; g < NUM_BLOCKS; g++) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lock_q[g] <= 1'b0;
        end else if (idle_go && (blk == BLK_W'(g))) begin
          if (code == OP_LOCK)   lock_q[g] <= 1'b1;
          if (code == OP_UNLOCK) lock_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      tmr_q     <= '0;
      op_prog_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_op) begin
          st_q      <= SQ_RUN;
          op_prog_q <= is_prog_op(code);
          tmr_q     <= is_prog_op(code) ? TW'(PROG_CYCLES) : TW'(ERASE_CYCLES);
        end
        SQ_RUN: begin
          if (tmr_last)     st_q <= SQ_IDLE;
          else if (susp_go) st_q <= SQ_SUSP;
          else              tmr_q <= tmr_q - TW'(1);
        end
        SQ_SUSP: if (resume_op) st_q <= SQ_RUN;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  p_susp_bits_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_susp, ers_susp, running}));

  p_susp_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_susp || ers_susp) |=> $stable(tmr_q));

  p_resume_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_op |=> running && !pgm_susp && !ers_susp);

  p_lock_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_abort |=> !running);

  p_vpp_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_abort |=> !running);

  p_done_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_prog || done_erase) |=> !running && !pgm_susp && !ers_susp);

endmodule

// File: rtl/fcw_status.sv
module fcw_status
  import fcw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_clear,
  input  logic        lock_abort,
  input  logic        vpp_abort,
  input  logic        done_prog,
  input  logic        done_erase,
  input  logic        prog_fail,
  input  logic        erase_fail,
  input  logic [1:0]  region_code,
  input  logic        ao_fail,
  input  logic        rdy,
  input  logic        pgm_susp,
  input  logic        ers_susp,
  output logic [15:0] status
);

  logic [15:0] err_q;
  logic [15:0] err_set;

  assign err_set = err_events(lock_abort, vpp_abort, done_prog, done_erase,
                              prog_fail, erase_fail, region_code, ao_fail);
  assign status  = status_word(err_q, rdy, pgm_susp, ers_susp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (rd_clear ? 16'h0000 : err_q) | err_set;
  end

  p_avail_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status[15] && ((status & ~ERR_MASK & ~16'h80C4) == 16'h0000));

  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !lock_abort && !vpp_abort && !done_prog && !done_erase)
      |=> ((status & ERR_MASK) == 16'h0000));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clear && status[4]) |=> status[4]);

endmodule

// File: rtl/flash_cmd_window.sv
module flash_cmd_window
  import fcw_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          PROG_CYCLES  = 20,
  parameter int          ERASE_CYCLES = 40,
  parameter int          NUM_BLOCKS   = 16,
  parameter logic [15:0] MFR_ID       = 16'h0089,
  parameter logic [15:0] DEV_ID       = 16'h88B0,
  parameter logic [15:0] PBUF_LOC     = 16'h0400,
  parameter logic [15:0] PBUF_WORDS   = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              rd_valid,
  input  logic              vpp_low,
  input  logic              prog_fail,
  input  logic              erase_fail,
  input  logic [1:0]        region_code,
  input  logic              ao_fail,
  output logic              ready,
  output logic              buf_clear
);

  logic [15:0] code_q, data_q, adr_lo_q, adr_hi_q, cnt_lo_q, cnt_hi_q;
  logic        exec_go, susp_go, clr_go;
  logic        running, pgm_susp, ers_susp;
  logic        lock_abort, vpp_abort, done_prog, done_erase;
  logic [15:0] status;
  logic        stat_rd;
  logic [15:0] rd_mux;

  fcw_regs #(.ADDR_W(ADDR_W), .DW(16)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .block_wr(running),
    .code_q(code_q), .data_q(data_q), .adr_lo_q(adr_lo_q),
    .adr_hi_q(adr_hi_q), .cnt_lo_q(cnt_lo_q), .cnt_hi_q(cnt_hi_q),
    .exec_go(exec_go), .susp_go(susp_go), .clr_go(clr_go)
  );

  fcw_seq #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES),
            .NUM_BLOCKS(NUM_BLOCKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .exec_go(exec_go), .susp_go(susp_go),
    .code(code_q), .blk_sel(adr_hi_q), .vpp_low(vpp_low),
    .running(running), .pgm_susp(pgm_susp), .ers_susp(ers_susp),
    .lock_abort(lock_abort), .vpp_abort(vpp_abort),
    .done_prog(done_prog), .done_erase(done_erase)
  );

  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));

  fcw_status u_status (
    .clk(clk), .rst_n(rst_n), .rd_clear(stat_rd),
    .lock_abort(lock_abort), .vpp_abort(vpp_abort),
    .done_prog(done_prog), .done_erase(done_erase),
    .prog_fail(prog_fail), .erase_fail(erase_fail),
    .region_code(region_code), .ao_fail(ao_fail),
    .rdy(!running), .pgm_susp(pgm_susp), .ers_susp(ers_susp),
    .status(status)
  );

  always_comb begin
    rd_mux = 16'h0000;
    case (bus_addr)
      ADDR_W'(OFS_SIG0):   rd_mux = 16'h0050;
      ADDR_W'(OFS_SIG1):   rd_mux = 16'h0046;
      ADDR_W'(OFS_SIG2):   rd_mux = 16'h004F;
      ADDR_W'(OFS_SIG3):   rd_mux = 16'h0057;
      ADDR_W'(OFS_MFR):    rd_mux = MFR_ID;
      ADDR_W'(OFS_DEV):    rd_mux = DEV_ID;
      ADDR_W'(OFS_PBLOC):  rd_mux = PBUF_LOC;
      ADDR_W'(OFS_PBSZ):   rd_mux = PBUF_WORDS;
      ADDR_W'(OFS_CODE):   rd_mux = code_q;
      ADDR_W'(OFS_DATA):   rd_mux = data_q;
      ADDR_W'(OFS_ADR_LO): rd_mux = adr_lo_q;
      ADDR_W'(OFS_ADR_HI): rd_mux = adr_hi_q;
      ADDR_W'(OFS_CNT_LO): rd_mux = cnt_lo_q;
      ADDR_W'(OFS_CNT_HI): rd_mux = cnt_hi_q;
      ADDR_W'(OFS_STAT):   rd_mux = status;
      default:             rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
      buf_clear <= 1'b0;
    end else begin
      rd_valid  <= bus_rd;
      buf_clear <= clr_go;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign ready = !running;

  p_rd_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  p_clr_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> !buf_clear || $past(clr_go));

endmodule

// File: tb/tb_flash_cmd_window.sv
module tb_flash_cmd_window;
  localparam int PC = 20;
  localparam int EC = 40;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rd_valid;
  logic        vpp_low = 0, prog_fail = 0, erase_fail = 0, ao_fail = 0;
  logic [1:0]  region_code = 2'b00;
  logic        ready, buf_clear;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  flash_cmd_window #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_valid(rd_valid), .vpp_low(vpp_low), .prog_fail(prog_fail),
    .erase_fail(erase_fail), .region_code(region_code), .ao_fail(ao_fail),
    .ready(ready), .buf_clear(buf_clear)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver tasks: entered and left at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  // Monitor: pops one expectation per returned read.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R13 unexpected read", 16'h1, 16'h0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic run_cmd(input logic [15:0] code, input logic [15:0] blk);
    wr(8'h8A, blk);
    wr(8'h80, code);
    wr(8'hC0, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R4 reset ready", {15'b0, ready}, 16'h1);
    rd(8'hCC, 16'h8080, "R11 reset status");
    rd(8'h80, 16'h0000, "R2 reset code");

    rd(8'h00, 16'h0050, "R1 sig P");
    rd(8'h02, 16'h0046, "R1 sig F");
    rd(8'h04, 16'h004F, "R1 sig O");
    rd(8'h06, 16'h0057, "R1 sig W");
    rd(8'h20, 16'h0089, "R1 mfr");
    rd(8'h22, 16'h88B0, "R1 dev");
    rd(8'h40, 16'h0400, "R1 pbuf loc");
    rd(8'h42, 16'h0200, "R1 pbuf words");

    wr(8'h84, 16'hA5A5); wr(8'h88, 16'h1234); wr(8'h90, 16'h0010); wr(8'h92, 16'h0002);
    rd(8'h84, 16'hA5A5, "R2 data");
    rd(8'h88, 16'h1234, "R2 adr lo");
    rd(8'h90, 16'h0010, "R2 cnt lo");
    rd(8'h92, 16'h0002, "R2 cnt hi");
    rd(8'h70, 16'h0000, "R2 unmapped");

    // R12 buffer clear strobe
    wr(8'hC4, 16'h0001);
    chk("R12 clear pulse", {15'b0, buf_clear}, 16'h1);
    @(negedge clk);
    chk("R12 pulse one cycle", {15'b0, buf_clear}, 16'h0);
    wr(8'hC4, 16'h0003);
    chk("R12 bad value no pulse", {15'b0, buf_clear}, 16'h0);

    // R3 wrong execute value
    wr(8'h8A, 16'h0001);
    wr(8'h80, 16'h0041);
    wr(8'hC0, 16'h0002);
    chk("R3 bad go value", {15'b0, ready}, 16'h1);
    wr(8'h80, 16'h0033);
    wr(8'hC0, 16'h0001);
    chk("R4 unknown code", {15'b0, ready}, 16'h1);

    // R4 + R10 program with all result inputs set
    prog_fail = 1; ao_fail = 1; region_code = 2'b11;
    run_cmd(16'h0041, 16'h0001);
    chk("R4 busy after go", {15'b0, ready}, 16'h0);
    wr(8'h80, 16'h0099);
    repeat (PC - 2) @(negedge clk);
    chk("R4 busy at end-1", {15'b0, ready}, 16'h0);
    @(negedge clk);
    chk("R4 ready at end", {15'b0, ready}, 16'h1);
    prog_fail = 0; ao_fail = 0; region_code = 2'b00;
    rd(8'h80, 16'h0041, "R5 code kept while busy");
    rd(8'hCC, 16'h9390, "R10 program results");
    rd(8'hCC, 16'h8080, "R11 cleared after read");

    // R6 R7 erase suspend/resume timing
    erase_fail = 1;
    run_cmd(16'h0020, 16'h0002);
    repeat (10) @(negedge clk);
    wr(8'hC8, 16'h0001);
    chk("R6 ready when suspended", {15'b0, ready}, 16'h1);
    rd(8'hCC, 16'h80C0, "R6 erase suspend bit");
    rd(8'hCC, 16'h80C0, "R11 read-only bits kept");
    repeat (50) @(negedge clk);
    wr(8'h80, 16'h0041);
    wr(8'hC0, 16'h0001);
    chk("R7 non-resume ignored", {15'b0, ready}, 16'h1);
    wr(8'h80, 16'h00D0);
    wr(8'hC0, 16'h0001);
    chk("R7 resumed busy", {15'b0, ready}, 16'h0);
    repeat (EC - 11) @(negedge clk);
    chk("R7 busy before remaining end", {15'b0, ready}, 16'h0);
    @(negedge clk);
    chk("R7 done after remaining", {15'b0, ready}, 16'h1);
    erase_fail = 0;
    rd(8'hCC, 16'h80A0, "R10 erase fail bit");
    rd(8'hCC, 16'h8080, "R11 erase bit cleared");

    // R6 program suspend
    run_cmd(16'h00E9, 16'h0004);
    repeat (3) @(negedge clk);
    wr(8'hC8, 16'h0001);
    rd(8'hCC, 16'h8084, "R6 program suspend bit");
    run_cmd(16'h00D0, 16'h0004);
    repeat (PC) @(negedge clk);
    rd(8'hCC, 16'h8080, "R7 suspend bit cleared");

    // R8 lock table
    run_cmd(16'h0061, 16'h0003);
    run_cmd(16'h0041, 16'h0003);
    chk("R8 locked no start", {15'b0, ready}, 16'h1);
    rd(8'hCC, 16'h8082, "R8 lock abort bit");
    rd(8'hCC, 16'h8080, "R8 lock bit cleared");
    run_cmd(16'h0020, 16'h0005);
    chk("R8 other block runs", {15'b0, ready}, 16'h0);
    repeat (EC) @(negedge clk);
    run_cmd(16'h0062, 16'h0003);
    run_cmd(16'h0041, 16'h0003);
    chk("R8 unlocked runs", {15'b0, ready}, 16'h0);
    repeat (PC) @(negedge clk);
    rd(8'hCC, 16'h8080, "R8 clean program");

    // R9 low supply
    vpp_low = 1;
    run_cmd(16'h0020, 16'h0006);
    chk("R9 vpp no start", {15'b0, ready}, 16'h1);
    rd(8'hCC, 16'h8088, "R9 vpp bit");
    vpp_low = 0;
    rd(8'hCC, 16'h8080, "R9 vpp cleared");

    repeat (3) @(negedge clk);
    chk("R13 all reads returned", 16'(exp_q.size()), 16'h0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule